// File: doc/BRIEF.md
# Protected Wiper Register Bank

This block keeps the wiper settings of three digitally controlled potentiometers of different resolutions, plus one control/status register. A serial command decoder in front of it hands over write requests that have already been parsed. Each request names a target register, carries a data byte and says whether the write is volatile (live setting only) or nonvolatile (live setting and its retained copy). The retained copies are modelled as shadow registers that keep their contents through reset, and at reset they are reloaded into the live wipers.

Two levels of protection gate every write. They are controlled by a write-protect input pin and a lock bit kept in the control register. With the pin high, no nonvolatile write is accepted. With the pin high and the lock bit set, no write at all is accepted. The control register also captures two voltage-monitor comparator outputs as status bits. A combinational read port returns any register, zero-extended to eight bits.

Top module: `wiper_bank_top`

## Requirements
- R1: Register selects are 0 = wiper A (64 taps, 6 bits), 1 = wiper B (100 taps, 7 bits), 2 = wiper C (256 taps, 8 bits) and 3 = control. `rd_data` returns the selected register, with bits above its width reading 0.
- R2: A value written to a wiper is clamped to its top tap. Wiper B takes a maximum of 99 and wiper A a maximum of 63, and a wiper never holds a value above its top tap.
- R3: An accepted volatile write changes only the live register. A later reset restores the retained value.
- R4: An accepted nonvolatile write changes both the live register and its retained copy, so the new value survives reset.
- R5: While `wp` is 1, every nonvolatile write request is rejected.
- R6: While `wp` is 1 and the lock bit is 1, every write request is rejected, volatile or not, wipers included.
- R7: While `wp` is 0, both kinds of write are accepted. While `wp` is 1 with the lock bit 0, volatile wiper writes are accepted.
- R8: Control bit 0 is the lock bit. Writes to the control register (only bit 0 is writable) are accepted only while `wp` is 0. A nonvolatile control write also sets the lock bit's retained copy.
- R9: Control bit 1 follows `mon_a` and bit 2 follows `mon_b`, each sampled one clock edge earlier. Bits 7:3 read 0.
- R10: Each request produces, on the clock edge that samples it, a one-cycle pulse on exactly one of `ack_ok` or `ack_bad`. A rejected request leaves every register unchanged.
- R11: Reset loads every live wiper and the lock bit from their retained copies. The retained copies start at parameter values (32, 50, 128, lock 0) and are not changed by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present this cycle |
| req_sel | input | 2 | Target register select |
| req_nv | input | 1 | 1 = nonvolatile write, 0 = volatile write |
| req_data | input | 8 | Write data |
| wp | input | 1 | Write-protect pin, active high |
| mon_a | input | 1 | First voltage-monitor comparator output |
| mon_b | input | 1 | Second voltage-monitor comparator output |
| rd_sel | input | 2 | Readback register select |
| rd_data | output | 8 | Readback value, zero-extended |
| ack_ok | output | 1 | Request accepted pulse |
| ack_bad | output | 1 | Request rejected pulse |
| wiper_a | output | 6 | Live wiper A setting |
| wiper_b | output | 7 | Live wiper B setting |
| wiper_c | output | 8 | Live wiper C setting |

## Verification
A request sampled at a rising edge has its outcome registered at that same edge: the accept or reject pulse and the new register contents are both visible one clock later. The read port adds no delay on top of that. Monitor status trails its inputs by one edge, and after reset is released the wipers already hold their retained values at the first edge. The bench drives inputs at falling edges and compares at the next falling edge, or 1 ns after changing `rd_sel`, so each result is read exactly in the half-cycle where it is due.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    localparam int DW = 8;

    localparam int CTRL_LOCK_BIT = 0;
    localparam int CTRL_STA_BIT  = 1;
    localparam int CTRL_STB_BIT  = 2;

    typedef enum logic [1:0] {
        SEL_POT_A = 2'd0,
        SEL_POT_B = 2'd1,
        SEL_POT_C = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic          valid;
        reg_sel_e      sel;
        logic          nv;
        logic [DW-1:0] data;
    } wr_req_t;

    function automatic logic [DW-1:0] clamp_to(input logic [DW-1:0] v,
                                               input logic [DW-1:0] maxv);
        return (v > maxv) ? maxv : v;
    endfunction

endpackage

// File: rtl/wpb_gate.sv
module wpb_gate
    import wpb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    input  logic    wp,
    input  logic    lock,
    output logic    accept,
    output logic    ack_ok,
    output logic    ack_bad
);

    logic blocked;

    // Pin alone stops retained writes and control writes; pin plus lock stops all.
    assign blocked = wp & (req.nv | lock | (req.sel == SEL_CTRL));
    assign accept  = req.valid & ~blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_ok  <= 1'b0;
            ack_bad <= 1'b0;
        end else begin
            ack_ok  <= req.valid & ~blocked;
            ack_bad <= req.valid & blocked;
        end
    end

    // R5
    p_nv_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        (req.valid && wp && req.nv) |=> ack_bad);

    // R6
    p_lock_blocks_all_r6: assert property (@(posedge clk) disable iff (rst)
        (req.valid && wp && lock) |=> ack_bad);

    // R7
    p_open_pin_r7: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !wp) |=> ack_ok);

    // R8
    p_ctrl_pin_r8: assert property (@(posedge clk) disable iff (rst)
        (req.valid && wp && req.sel == SEL_CTRL) |=> ack_bad);

    // R10
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !(ack_ok && ack_bad));

    p_strobe_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
        (!req.valid) |=> (!ack_ok && !ack_bad));

endmodule

// File: rtl/wpb_wiper_cell.sv
module wpb_wiper_cell
    import wpb_pkg::*;
#(
    parameter int         W     = 6,
    parameter int         TAPS  = 64,
    parameter logic [W-1:0] INITV = '0
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_live,
    input  logic          wr_nv,
    input  logic [DW-1:0] din,
    output logic [W-1:0]  q
);

    localparam logic [DW-1:0] MAXV = DW'(TAPS - 1);

    logic [W-1:0] lim;
    logic [W-1:0] shadow = INITV;

    assign lim = W'(clamp_to(din, MAXV));

    // Retained copy: never touched by reset.
    always_ff @(posedge clk) begin
        if (wr_nv) shadow <= lim;
    end

    always_ff @(posedge clk) begin
        if (rst)          q <= shadow;
        else if (wr_live) q <= lim;
    end

    // R2
    p_wiper_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        DW'(q) <= MAXV);

    // R3
    p_vol_keeps_shadow_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_live && !wr_nv) |=> $stable(shadow));

    // R4
    p_nv_sets_both_r4: assert property (@(posedge clk) disable iff (rst)
        wr_nv |=> (q == shadow));

endmodule

// File: rtl/wpb_ctrl_stat.sv
module wpb_ctrl_stat #(
    parameter logic INIT_LOCK = 1'b0
)(
    input  logic clk,
    input  logic rst,
    input  logic wr_live,
    input  logic wr_nv,
    input  logic din_lock,
    input  logic mon_a,
    input  logic mon_b,
    output logic lock,
    output logic st_a,
    output logic st_b
);

    logic lock_shadow = INIT_LOCK;

    always_ff @(posedge clk) begin
        if (wr_nv) lock_shadow <= din_lock;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock <= lock_shadow;
            st_a <= 1'b0;
            st_b <= 1'b0;
        end else begin
            if (wr_live) lock <= din_lock;
            st_a <= mon_a;
            st_b <= mon_b;
        end
    end

    // R9
    p_status_follow_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_a == $past(mon_a) && st_b == $past(mon_b)));

    // R8
    p_lock_only_by_write_r8: assert property (@(posedge clk) disable iff (rst)
        (!wr_live) |=> $stable(lock));

endmodule

// File: rtl/wiper_bank_top.sv
module wiper_bank_top
    import wpb_pkg::*;
#(
    parameter int        WA      = 6,
    parameter int        WB      = 7,
    parameter int        WC      = 8,
    parameter int        TAPS_A  = 64,
    parameter int        TAPS_B  = 100,
    parameter int        TAPS_C  = 256,
    parameter logic [WA-1:0] INIT_A = 6'd32,
    parameter logic [WB-1:0] INIT_B = 7'd50,
    parameter logic [WC-1:0] INIT_C = 8'd128,
    parameter logic      INIT_LOCK = 1'b0
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_sel,
    input  logic          req_nv,
    input  logic [7:0]    req_data,
    input  logic          wp,
    input  logic          mon_a,
    input  logic          mon_b,
    input  logic [1:0]    rd_sel,
    output logic [7:0]    rd_data,
    output logic          ack_ok,
    output logic          ack_bad,
    output logic [WA-1:0] wiper_a,
    output logic [WB-1:0] wiper_b,
    output logic [WC-1:0] wiper_c
);

    wr_req_t  req;
    logic     accept;
    logic     lock, st_a, st_b;
    logic     live_a, live_b, live_c, live_k;
    logic     nv_a, nv_b, nv_c, nv_k;

    assign req.valid = req_valid;
    assign req.sel   = reg_sel_e'(req_sel);
    assign req.nv    = req_nv;
    assign req.data  = req_data;

    wpb_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wp      (wp),
        .lock    (lock),
        .accept  (accept),
        .ack_ok  (ack_ok),
        .ack_bad (ack_bad)
    );

    assign live_a = accept & (req.sel == SEL_POT_A);
    assign live_b = accept & (req.sel == SEL_POT_B);
    assign live_c = accept & (req.sel == SEL_POT_C);
    assign live_k = accept & (req.sel == SEL_CTRL);
    assign nv_a   = live_a & req.nv;
    assign nv_b   = live_b & req.nv;
    assign nv_c   = live_c & req.nv;
    assign nv_k   = live_k & req.nv;

    wpb_wiper_cell #(.W(WA), .TAPS(TAPS_A), .INITV(INIT_A)) u_cell_a (
        .clk(clk), .rst(rst), .wr_live(live_a), .wr_nv(nv_a),
        .din(req.data), .q(wiper_a)
    );

    wpb_wiper_cell #(.W(WB), .TAPS(TAPS_B), .INITV(INIT_B)) u_cell_b (
        .clk(clk), .rst(rst), .wr_live(live_b), .wr_nv(nv_b),
        .din(req.data), .q(wiper_b)
    );

    wpb_wiper_cell #(.W(WC), .TAPS(TAPS_C), .INITV(INIT_C)) u_cell_c (
        .clk(clk), .rst(rst), .wr_live(live_c), .wr_nv(nv_c),
        .din(req.data), .q(wiper_c)
    );

    wpb_ctrl_stat #(.INIT_LOCK(INIT_LOCK)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_live  (live_k),
        .wr_nv    (nv_k),
        .din_lock (req.data[CTRL_LOCK_BIT]),
        .mon_a    (mon_a),
        .mon_b    (mon_b),
        .lock     (lock),
        .st_a     (st_a),
        .st_b     (st_b)
    );

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_sel))
            SEL_POT_A: rd_data = DW'(wiper_a);
            SEL_POT_B: rd_data = DW'(wiper_b);
            SEL_POT_C: rd_data = DW'(wiper_c);
            default: begin
                rd_data[CTRL_LOCK_BIT] = lock;
                rd_data[CTRL_STA_BIT]  = st_a;
                rd_data[CTRL_STB_BIT]  = st_b;
            end
        endcase
    end

    // R10
    p_reject_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ack_bad |-> ($stable(wiper_a) && $stable(wiper_b) &&
                     $stable(wiper_c) && $stable(lock)));

    // R6
    p_locked_wipers_r6: assert property (@(posedge clk) disable iff (rst)
        (wp && lock) |=> ($stable(wiper_a) && $stable(wiper_b) && $stable(wiper_c)));

    // R1
    p_ctrl_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd3) |-> (rd_data[7:3] == 5'd0));

endmodule

// File: tb/sim_wiper_bank_top.sv
module sim_wiper_bank_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_sel = 2'd0;
    logic       req_nv = 1'b0;
    logic [7:0] req_data = 8'd0;
    logic       wp = 1'b0;
    logic       mon_a = 1'b0;
    logic       mon_b = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       ack_ok, ack_bad;
    logic [5:0] wiper_a;
    logic [6:0] wiper_b;
    logic [7:0] wiper_c;

    int n_cmp  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wiper_bank_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_nv(req_nv), .req_data(req_data), .wp(wp), .mon_a(mon_a),
        .mon_b(mon_b), .rd_sel(rd_sel), .rd_data(rd_data), .ack_ok(ack_ok),
        .ack_bad(ack_bad), .wiper_a(wiper_a), .wiper_b(wiper_b), .wiper_c(wiper_c)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, input string tag, input logic [7:0] exp);
        rd_sel = sel;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data, input logic nv,
                      input logic exp_ok, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_data = data; req_nv = nv;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " ack_ok"},  {7'd0, ack_ok},  {7'd0, exp_ok});
        chk({tag, " ack_bad"}, {7'd0, ack_bad}, {7'd0, ~exp_ok});
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        rd(2'd0, "R11 wiper A init", 8'd32);
        rd(2'd1, "R11 wiper B init", 8'd50);
        rd(2'd2, "R11 wiper C init", 8'd128);
        rd(2'd3, "R11 ctrl init", 8'd0);
        chk("R10 no strobe idle", {6'd0, ack_ok, ack_bad}, 8'd0);
    endtask

    task automatic t_volatile();
        wr(2'd0, 8'd10, 1'b0, 1'b1, "R7 vol A");
        rd(2'd0, "R3 vol A live", 8'd10);
        chk("R1 wiper_a port", {2'd0, wiper_a}, 8'd10);
        do_reset();
        rd(2'd0, "R3 vol A reverts", 8'd32);
    endtask

    task automatic t_nonvolatile();
        wr(2'd2, 8'd200, 1'b1, 1'b1, "R7 nv C");
        wr(2'd1, 8'd77, 1'b1, 1'b1, "R7 nv B");
        rd(2'd2, "R4 nv C live", 8'd200);
        rd(2'd1, "R4 nv B live", 8'd77);
        do_reset();
        rd(2'd2, "R4 nv C kept", 8'd200);
        rd(2'd1, "R4 nv B kept", 8'd77);
        rd(2'd0, "R11 A from shadow", 8'd32);
    endtask

    task automatic t_clamp();
        wr(2'd1, 8'd150, 1'b0, 1'b1, "R2 B 150");
        rd(2'd1, "R2 B clamp 150", 8'd99);
        wr(2'd1, 8'd100, 1'b0, 1'b1, "R2 B 100");
        rd(2'd1, "R2 B clamp 100", 8'd99);
        wr(2'd1, 8'd98, 1'b0, 1'b1, "R2 B 98");
        rd(2'd1, "R2 B 98 passes", 8'd98);
        wr(2'd0, 8'd70, 1'b0, 1'b1, "R2 A 70");
        rd(2'd0, "R1 R2 A clamp zero-ext", 8'd63);
        wr(2'd2, 8'd255, 1'b0, 1'b1, "R2 C 255");
        rd(2'd2, "R1 C full range", 8'd255);
    endtask

    task automatic t_pin_nv();
        wp = 1'b1;
        wr(2'd2, 8'd5, 1'b1, 1'b0, "R5 nv C under pin");
        rd(2'd2, "R10 C unchanged", 8'd255);
        wr(2'd2, 8'd5, 1'b0, 1'b1, "R7 vol C under pin");
        rd(2'd2, "R7 vol C applied", 8'd5);
        wp = 1'b0;
        do_reset();
        rd(2'd2, "R5 shadow C kept", 8'd200);
    endtask

    task automatic t_lock();
        wr(2'd0, 8'd63, 1'b0, 1'b1, "R7 A set");
        wr(2'd3, 8'd1, 1'b0, 1'b1, "R8 lock set");
        rd(2'd3, "R8 lock reads 1", 8'd1);
        wp = 1'b1;
        wr(2'd0, 8'd9, 1'b0, 1'b0, "R6 vol A locked");
        rd(2'd0, "R6 A unchanged", 8'd63);
        wr(2'd1, 8'd9, 1'b1, 1'b0, "R6 nv B locked");
        rd(2'd1, "R6 B unchanged", 8'd77);
        wr(2'd3, 8'd0, 1'b0, 1'b0, "R8 lock clear under pin");
        rd(2'd3, "R8 lock still 1", 8'd1);
        wp = 1'b0;
        wr(2'd0, 8'd9, 1'b0, 1'b1, "R7 vol A lock no pin");
        rd(2'd0, "R7 A applied", 8'd9);
        do_reset();
        rd(2'd3, "R3 volatile lock reverts", 8'd0);
        wr(2'd3, 8'd1, 1'b1, 1'b1, "R8 nv lock set");
        wr(2'd3, 8'd0, 1'b0, 1'b1, "R8 vol lock clear");
        rd(2'd3, "R8 lock live 0", 8'd0);
        do_reset();
        rd(2'd3, "R11 lock from shadow", 8'd1);
        wr(2'd3, 8'd0, 1'b1, 1'b1, "R8 nv lock clear");
        rd(2'd3, "R8 lock cleared", 8'd0);
    endtask

    task automatic t_status();
        @(negedge clk); mon_a = 1'b1;
        @(negedge clk);
        rd(2'd3, "R9 mon_a high", 8'd2);
        mon_b = 1'b1;
        @(negedge clk);
        rd(2'd3, "R9 both high", 8'd6);
        mon_a = 1'b0;
        @(negedge clk);
        rd(2'd3, "R9 mon_b only", 8'd4);
        wr(2'd3, 8'hFE, 1'b0, 1'b1, "R8 ctrl write only lock bit");
        rd(2'd3, "R9 status not writable", 8'd4);
        mon_b = 1'b0;
        @(negedge clk);
        rd(2'd3, "R9 both low", 8'd0);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_volatile();
        t_nonvolatile();
        t_clamp();
        t_pin_nv();
        t_lock();
        t_status();
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule